// File: doc/BRIEF.md
# Processor External Bus Cycle Sequencer

This block runs the external bus of a processor core for single transfers to memory or to I/O ports. A client offers a request with a two-bit kind, a 20-bit address and 16 bits of write data. The sequencer takes the request when it is free. It then walks the bus through the clock states T1, T2, T3 and T4. It drives the address and its latch-enable pulse, the read or write strobe, the memory/I/O select and the write data. It samples a READY input to stretch the transfer, and it returns read data together with a one-cycle done pulse.

A transfer never takes fewer than four clocks. A slow device holds READY low, and each clock it does so adds one wait state between T3 and T4. When no request is waiting, the bus sits idle. A request that is already waiting in T4 is taken there, and its T1 follows on the next clock with no idle state between the two transfers.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and right after it, the sequencer is idle: `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_doe`=0, `rsp_done`=0, `bus_addr`=0 and `req_ready`=1.
- R2: `req_ready` is high only in the idle state and in T4. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. With `req_valid` low the bus stays idle and `bus_ale` does not rise.
- R3: `bus_ale` is high for exactly one clock, the T1 that follows acceptance. `bus_addr` carries the address only in that clock and is zero in every other clock.
- R4: Kind encoding: bit 1 set selects I/O and bit 0 set selects a write (00 memory read, 01 memory write, 10 I/O read, 11 I/O write). A memory cycle drives all 20 address bits with `bus_mio`=1. An I/O cycle drives only address bits 15:0, forces bits 19:16 to zero and has `bus_mio`=0.
- R5: The strobe for the cycle's direction (`bus_rd_n` for reads, `bus_wr_n` for writes) is low in T2, in T3 and in every wait state. Both strobes are high in T1 and T4, and they are never low together.
- R6: During the write strobe, `bus_doe`=1 and `bus_dout` equals the request's write data. `bus_doe` is 0 in every other clock.
- R7: READY is sampled at the edge that ends T3 and at the edge that ends each wait state. Each sample that finds it low adds one wait state, so a transfer with N low samples lasts 4+N clocks from T1 through T4.
- R8: On a read, `rsp_rdata` takes the value of `bus_din` at the edge that enters T4 and holds it afterwards. A write cycle leaves `rsp_rdata` unchanged.
- R9: `rsp_done` is high for exactly the T4 clock of each transfer.
- R10: A request that is waiting while the sequencer is in T4 is taken there, and its T1 is the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 2 | Bit 1: I/O, bit 0: write |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer can take a request this clock |
| bus_ready | input | 1 | Device ready; low inserts wait states |
| bus_din | input | 16 | Read data from the bus |
| bus_addr | output | 20 | Address, valid in T1 |
| bus_ale | output | 1 | Address latch enable, high in T1 |
| bus_mio | output | 1 | 1 for memory, 0 for I/O |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| rsp_done | output | 1 | Transfer complete pulse (T4) |
| rsp_rdata | output | 16 | Last captured read data |

## Verification
Acceptance takes one edge. T1 is therefore the first clock after the accepting edge, the strobe appears one clock later, and `rsp_done` with the captured data shows 3+N clocks after T1, where N is the number of wait states asked for. The bench drives at the falling edge and samples each output at the falling edge of the clock in which that state must hold, walking T1, T2, T3, each wait state and T4 in turn. It presents the correct `bus_din` only in the clock before the capturing edge and a complemented value in every other clock, so a capture one clock early or late shows up as a mismatch.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bcs_state_e;

  // kind bit 0: write, bit 1: I/O
  function automatic logic kind_write(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_io(input logic [1:0] k);
    return k[1];
  endfunction

  // states in which a strobe is active
  function automatic logic in_strobe(input bcs_state_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  // states in which READY is sampled at the closing edge
  function automatic logic ready_window(input bcs_state_e s);
    return (s == ST_T3) || (s == ST_TW);
  endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       bus_ready,
  output bcs_state_e state,
  output logic       accept_evt,
  output logic       wait_evt,
  output logic       cap_evt
);

  bcs_state_e state_q, state_d;

  assign state      = state_q;
  assign accept_evt = req_valid && ((state_q == ST_IDLE) || (state_q == ST_T4));
  assign wait_evt   = ready_window(state_q) && !bus_ready;
  assign cap_evt    = ready_window(state_q) && bus_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_evt) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = bus_ready ? ST_T4 : ST_TW;
      ST_T4:   state_d = accept_evt ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    wait_evt |=> (state_q == ST_TW)); // R7
  AST_T4_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (state_q == ST_T4)); // R7
  AST_T4_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T4) |-> ready_window($past(state_q))); // R7
  AST_CHAIN_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_T4) && req_valid) |=> (state_q == ST_T1)); // R10
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !req_valid) |=> (state_q == ST_IDLE)); // R2

endmodule

// File: rtl/bcs_xfer_regs.sv
module bcs_xfer_regs #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_evt,
  input  logic          cap_evt,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_din,
  output logic [1:0]    cur_kind,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic [DW-1:0] rdata
);

  logic rd_capture;
  assign rd_capture = cap_evt && !bcs_pkg::kind_write(cur_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_kind  <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept_evt) begin
      cur_kind  <= req_kind;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (rd_capture) rdata <= bus_din;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rdata)); // R8
  AST_RDATA_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> (rdata == $past(bus_din))); // R8

endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int AW  = 20,
  parameter int IOW = 16,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bcs_state_e    state,
  input  logic [1:0]    cur_kind,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ale,
  output logic          bus_mio,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          rsp_done,
  output logic          req_ready
);

  localparam logic [AW-1:0] IO_MASK = {{(AW-IOW){1'b0}}, {IOW{1'b1}}};

  function automatic logic [AW-1:0] form_addr(input logic [1:0] k, input logic [AW-1:0] a);
    return kind_io(k) ? (a & IO_MASK) : a;
  endfunction

  logic strobe_on, is_wr, active;

  assign is_wr     = kind_write(cur_kind);
  assign strobe_on = in_strobe(state);
  assign active    = (state != ST_IDLE);

  assign bus_ale   = (state == ST_T1);
  assign bus_addr  = bus_ale ? form_addr(cur_kind, cur_addr) : '0;
  assign bus_mio   = active && !kind_io(cur_kind);
  assign bus_rd_n  = !(strobe_on && !is_wr);
  assign bus_wr_n  = !(strobe_on && is_wr);
  assign bus_doe   = strobe_on && is_wr;
  assign bus_dout  = bus_doe ? cur_wdata : '0;
  assign rsp_done  = (state == ST_T4);
  assign req_ready = (state == ST_IDLE) || (state == ST_T4);

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R5
  AST_ALE_QUIET_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n)); // R5
  AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (!bus_rd_n || !bus_wr_n)); // R5
  AST_DONE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (bus_rd_n && bus_wr_n && !bus_doe)); // R9
  AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ale && !bus_mio) |-> ((bus_addr & ~IO_MASK) == '0)); // R4
  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale); // R3

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW  = 20,
  parameter int IOW = 16,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic          bus_ale,
  output logic          bus_mio,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);

  bcs_pkg::bcs_state_e state;
  logic          accept_evt, wait_evt, cap_evt;
  logic [1:0]    cur_kind;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  bcs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .bus_ready  (bus_ready),
    .state      (state),
    .accept_evt (accept_evt),
    .wait_evt   (wait_evt),
    .cap_evt    (cap_evt)
  );

  bcs_xfer_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_evt (accept_evt),
    .cap_evt    (cap_evt),
    .req_kind   (req_kind),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .bus_din    (bus_din),
    .cur_kind   (cur_kind),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .rdata      (rsp_rdata)
  );

  bcs_pins #(.AW(AW), .IOW(IOW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cur_kind  (cur_kind),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .bus_addr  (bus_addr),
    .bus_ale   (bus_ale),
    .bus_mio   (bus_mio),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rsp_done  (rsp_done),
    .req_ready (req_ready)
  );

  AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wait_evt |=> !rsp_done); // R7
  AST_ACCEPT_TO_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> bus_ale); // R3

endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic        bus_ready = 1'b1;
  logic [15:0] bus_din = '0;
  logic [19:0] bus_addr;
  logic        bus_ale, bus_mio, bus_rd_n, bus_wr_n, bus_doe, rsp_done;
  logic [15:0] bus_dout, rsp_rdata;

  int total = 0;
  int bad = 0;
  bit ended = 0;
  logic [15:0] last_rd = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .bus_ready(bus_ready), .bus_din(bus_din), .bus_addr(bus_addr),
    .bus_ale(bus_ale), .bus_mio(bus_mio), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  // {kind[1:0], addr[19:0], wdata[15:0], din[15:0], waits[3:0]}
  localparam logic [57:0] VEC [0:5] = '{
    {2'b00, 20'hF1234, 16'h0000, 16'hA55A, 4'd0},
    {2'b01, 20'h00010, 16'h1357, 16'h0000, 4'd0},
    {2'b10, 20'hABCDE, 16'h0000, 16'h0F0F, 4'd2},
    {2'b11, 20'h7FFFF, 16'hBEEF, 16'h0000, 4'd1},
    {2'b00, 20'hFFFFF, 16'h0000, 16'h8001, 4'd5},
    {2'b01, 20'h80000, 16'hFFFF, 16'h0000, 4'd3}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe_chk(input logic [1:0] k, input string req);
    if (k[0]) chk(!bus_wr_n && bus_rd_n, req, {bus_rd_n, bus_wr_n}, 2'b10);
    else      chk(!bus_rd_n && bus_wr_n, req, {bus_rd_n, bus_wr_n}, 2'b01);
  endtask

  // Runs one transfer; returns at the falling edge inside T4.
  task automatic xfer(input logic [1:0] k, input logic [19:0] a, input logic [15:0] wd,
                      input logic [15:0] din, input int waits, input bit chained);
    logic [19:0] ea;
    ea = k[1] ? {4'h0, a[15:0]} : a;
    if (!chained) @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before accept", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    bus_din = ~din;
    @(negedge clk); // T1
    req_valid = 1'b0;
    if (chained) chk(bus_ale == 1'b1, "R10 T1 right after T4", {31'd0, bus_ale}, 1);
    chk(bus_ale == 1'b1, "R3 ale in T1", {31'd0, bus_ale}, 1);
    chk(bus_addr == ea, "R4 address in T1", {12'd0, bus_addr}, {12'd0, ea});
    chk(bus_mio == !k[1], "R4 mio select", {31'd0, bus_mio}, {31'd0, !k[1]});
    chk(bus_rd_n && bus_wr_n, "R5 strobes off in T1", {bus_rd_n, bus_wr_n}, 2'b11);
    chk(rsp_done == 1'b0, "R9 no done in T1", {31'd0, rsp_done}, 0);
    @(negedge clk); // T2
    chk(bus_ale == 1'b0 && bus_addr == 20'h0, "R3 address off after T1", {11'd0, bus_ale, bus_addr}, 0);
    strobe_chk(k, "R5 strobe in T2");
    chk(bus_doe == k[0], "R6 data enable in T2", {31'd0, bus_doe}, {31'd0, k[0]});
    if (k[0]) chk(bus_dout == wd, "R6 write data", {16'd0, bus_dout}, {16'd0, wd});
    @(negedge clk); // T3
    strobe_chk(k, "R5 strobe in T3");
    chk(rsp_done == 1'b0, "R7 no done in T3", {31'd0, rsp_done}, 0);
    bus_ready = (waits == 0);
    bus_din = (waits == 0) ? din : ~din;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk); // wait state
      strobe_chk(k, "R7 strobe held in wait");
      chk(rsp_done == 1'b0, "R7 no done in wait", {31'd0, rsp_done}, 0);
      bus_ready = (i == waits - 1);
      bus_din = (i == waits - 1) ? din : ~din;
    end
    @(negedge clk); // T4
    chk(rsp_done == 1'b1, "R9 done in T4", {31'd0, rsp_done}, 1);
    chk(bus_rd_n && bus_wr_n && !bus_doe, "R5 strobes off in T4",
        {bus_rd_n, bus_wr_n, bus_doe}, 3'b110);
    if (!k[0]) last_rd = din;
    chk(rsp_rdata == last_rd, "R8 read data", {16'd0, rsp_rdata}, {16'd0, last_rd});
    bus_din = 16'hDEAD;
    bus_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n && !bus_doe && !rsp_done && bus_addr == 0,
        "R1 outputs in reset", {bus_ale, bus_rd_n, bus_wr_n, bus_doe, rsp_done}, 5'b01100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !bus_ale && rsp_rdata == 0, "R1 idle after reset",
        {req_ready, bus_ale}, 2'b10);

    // R2: no request, bus stays idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!bus_ale && !rsp_done && req_ready, "R2 idle without request",
          {bus_ale, rsp_done, req_ready}, 3'b001);
    end

    for (int v = 0; v < 6; v++) begin
      xfer(VEC[v][57:56], VEC[v][55:36], VEC[v][35:20], VEC[v][19:4], int'(VEC[v][3:0]), 1'b0);
      @(negedge clk);
      chk(!rsp_done && !bus_ale, "R9 done one clock only", {rsp_done, bus_ale}, 2'b00);
    end

    // R10: back-to-back, second request offered in T4
    xfer(2'b00, 20'h12345, 16'h0, 16'h4321, 0, 1'b0);
    xfer(2'b11, 20'hF0F0F, 16'h5AA5, 16'h0, 1, 1'b1);
    xfer(2'b10, 20'h0FFFF, 16'h0, 16'h7E7E, 0, 1'b1);
    @(negedge clk);
    chk(!bus_ale && !rsp_done, "R2 idle after chain", {bus_ale, rsp_done}, 2'b00);

    // R8: write after read leaves read data alone
    xfer(2'b01, 20'h00001, 16'h1111, 16'h0, 2, 1'b0);

    // R1: reset mid-transfer returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 20'h00100;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(bus_rd_n && bus_wr_n && !bus_ale && req_ready && rsp_rdata == 0, "R1 reset mid-cycle",
        {bus_rd_n, bus_wr_n, bus_ale, req_ready}, 4'b1101);
    last_rd = 16'h0;
    xfer(2'b10, 20'h0ABCD, 16'h0, 16'h3C3C, 4, 1'b0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule